// File: doc/BRIEF.md
# Millisecond Real-Time Clock with Coherent Seconds Capture

The block keeps wall time as two counters: a millisecond field that runs from 0 to 999 and a 32-bit seconds count that advances each time the millisecond field rolls over. Both advance on a 1 kHz tick enable supplied by the surrounding clocking logic. The counters run as long as the block is clocked and out of reset, so a system that keeps this domain powered through sleep keeps time through sleep.

Software reaches the counters through a small register port. Reads and writes take one cycle each, and read data appears one cycle after the request. The seconds count can be read live. A tear-free timestamp takes two reads. The first read is of the millisecond field. That read also copies the live seconds into a single capture register in the same clock edge. The second read is of that capture register. The value in 1 ms units is then `capture * 1000 + ms`. There is only one capture register, so a second agent that reads the millisecond field between another agent's two reads replaces the captured value.

Top module: `ms_rtc`

## Requirements
- R1: After reset the seconds count, the millisecond field, the capture register and `rdata_o` are all zero.
- R2: Each cycle with `tick_i` high advances the millisecond field by one. Cycles with `tick_i` low leave it unchanged.
- R3: A tick taken while the millisecond field is 999 sets it to 0 and increments the seconds count in the same clock edge.
- R4: A read of offset 0x10 returns the millisecond field, zero-extended, on `rdata_o` in the following cycle. At the same edge it copies the live seconds count into the capture register.
- R5: A read of offset 0x0C returns the capture register. The capture register changes only on a read of offset 0x10.
- R6: A read of offset 0x08 returns the live seconds count.
- R7: A write to offset 0x08 loads the seconds count with `wdata_i` and clears the millisecond field. It takes priority over a tick in the same cycle.
- R8: Writes to any offset other than 0x08 change no state.
- R9: A read of any offset other than 0x08, 0x0C or 0x10 returns zero. `rdata_o` is zero in the cycle after a cycle with no read.
- R10: A millisecond read in the same cycle as a rollover tick returns 999. The capture then holds the seconds value from before the increment, so the pair stays coherent.
- R11: The seconds count wraps from 0xFFFFFFFF to 0 on rollover.
- R12: A second millisecond read before the capture register is read overwrites the capture with the seconds value at the time of that second read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 1 kHz tick enable, one cycle wide |
| rd_en_i | input | 1 | Read request |
| wr_en_i | input | 1 | Write request |
| addr_i | input | 8 | Byte offset of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after `rd_en_i` |

## Verification
The assertions assume the following about the inputs:
- `tick_i` is a single-cycle enable.
- `rd_en_i` and `wr_en_i` are sampled only at rising edges.
- Nothing is assumed about how often ticks arrive relative to accesses.

The stimulus keeps within these assumptions by driving every input on the falling edge and holding each request for exactly one cycle. It also places a read and a rollover tick in the same cycle, places a seconds write and a tick in the same cycle, and interleaves millisecond reads. These exercise the collisions that the assertions guard, using only legal input patterns.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int SEC_W  = 32;
  localparam int MS_W   = 10;
  localparam int MS_MAX = 999;

  typedef enum logic [ADDR_W-1:0] {
    OFF_SECS   = 8'h08,
    OFF_CAPT   = 8'h0C,
    OFF_MSEC   = 8'h10
  } rtc_off_e;
endpackage

// File: rtl/rtc_ms_cnt.sv
module rtc_ms_cnt #(
  parameter int MS_W   = 10,
  parameter int MS_MAX = 999
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            clr_i,
  output logic [MS_W-1:0] ms_o,
  output logic            wrap_o
);
  localparam logic [MS_W-1:0] LAST = MS_W'(MS_MAX);

  logic [MS_W-1:0] ms_q;

  assign wrap_o = tick_i && !clr_i && (ms_q == LAST);
  assign ms_o   = ms_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         ms_q <= '0;
    else if (clr_i)      ms_q <= '0;
    else if (tick_i)     ms_q <= (ms_q == LAST) ? '0 : ms_q + 1'b1;
  end

  // R3
  ms_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ms_q <= LAST);

  // R3
  ms_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !clr_i && ms_q == LAST) |=> (ms_q == '0));

  // R2
  ms_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i) |=> $stable(ms_q));
endmodule

// File: rtl/rtc_sec_cnt.sv
module rtc_sec_cnt #(
  parameter int SEC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             load_i,
  input  logic [SEC_W-1:0] load_val_i,
  output logic [SEC_W-1:0] sec_o
);
  logic [SEC_W-1:0] sec_q;

  assign sec_o = sec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sec_q <= '0;
    else if (load_i)  sec_q <= load_val_i;
    else if (inc_i)   sec_q <= sec_q + 1'b1;
  end

  // R3
  sec_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !load_i) |=> (sec_q == $past(sec_q) + 1'b1));

  // R3
  sec_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !load_i) |=> $stable(sec_q));
endmodule

// File: rtl/rtc_regif.sv
module rtc_regif
  import rtc_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int SW = 32,
  parameter int MW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_en_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [SW-1:0] sec_i,
  input  logic [MW-1:0] ms_i,
  output logic          sec_load_o,
  output logic [SW-1:0] sec_val_o,
  output logic [DW-1:0] rdata_o
);
  logic          hit_sec, hit_capt, hit_ms;
  logic [SW-1:0] capt_q;
  logic [DW-1:0] rdata_d, rdata_q;

  assign hit_sec  = (addr_i == AW'(OFF_SECS));
  assign hit_capt = (addr_i == AW'(OFF_CAPT));
  assign hit_ms   = (addr_i == AW'(OFF_MSEC));

  assign sec_load_o = wr_en_i && hit_sec;
  assign sec_val_o  = SW'(wdata_i);

  always_comb begin
    rdata_d = '0;
    if (rd_en_i) begin
      if (hit_sec)       rdata_d = DW'(sec_i);
      else if (hit_capt) rdata_d = DW'(capt_q);
      else if (hit_ms)   rdata_d = DW'(ms_i);
    end
  end

  // capture is taken from pre-edge seconds, matching the ms value returned
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      capt_q  <= '0;
      rdata_q <= '0;
    end else begin
      rdata_q <= rdata_d;
      if (rd_en_i && hit_ms) capt_q <= sec_i;
    end
  end

  assign rdata_o = rdata_q;

  // R5
  capt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_en_i && hit_ms) |=> $stable(capt_q));

  // R4
  capt_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && hit_ms) |=> (capt_q == $past(sec_i)));

  // R9
  unmapped_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !hit_sec && !hit_capt && !hit_ms) |=> (rdata_o == '0));

  // R9
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> (rdata_o == '0));
endmodule

// File: rtl/ms_rtc.sv
module ms_rtc
  import rtc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [MS_W-1:0]  ms;
  logic [SEC_W-1:0] sec, sec_val;
  logic             wrap, sec_load;

  rtc_regif #(
    .AW(ADDR_W), .DW(DATA_W), .SW(SEC_W), .MW(MS_W)
  ) u_regif (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_en_i    (rd_en_i),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .sec_i      (sec),
    .ms_i       (ms),
    .sec_load_o (sec_load),
    .sec_val_o  (sec_val),
    .rdata_o    (rdata_o)
  );

  rtc_ms_cnt #(.MS_W(MS_W), .MS_MAX(MS_MAX)) u_ms (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .clr_i  (sec_load),
    .ms_o   (ms),
    .wrap_o (wrap)
  );

  rtc_sec_cnt #(.SEC_W(SEC_W)) u_sec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .inc_i      (wrap),
    .load_i     (sec_load),
    .load_val_i (sec_val),
    .sec_o      (sec)
  );

  // R7
  load_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(OFF_SECS)) |=> (ms == '0 && sec == $past(wdata_i)));

  // R8
  stray_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i != ADDR_W'(OFF_SECS) && !tick_i) |=> ($stable(ms) && $stable(sec)));
endmodule

// File: tb/sim_ms_rtc.sv
`timescale 1ns/1ps
module sim_ms_rtc;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        tick = 0, rd_en = 0, wr_en = 0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ms_rtc u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .rd_en_i(rd_en),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );

  // behavioural reference
  bit [31:0] m_secs, m_capt, m_rdata;
  int        m_ms;
  string     m_req = "R1";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_secs = 0; m_capt = 0; m_rdata = 0; m_ms = 0; m_req = "R1";
    end else begin
      m_rdata = 0; m_req = "R9";
      if (rd_en) begin
        case (addr)
          8'h08: begin m_rdata = m_secs; m_req = "R6"; end
          8'h0C: begin m_rdata = m_capt; m_req = "R5"; end
          8'h10: begin m_rdata = m_ms;   m_req = "R4"; m_capt = m_secs; end
          default: m_rdata = 0;
        endcase
      end
      if (wr_en && addr == 8'h08) begin
        m_secs = wdata; m_ms = 0;
      end else if (tick) begin
        if (m_ms == 999) begin m_ms = 0; m_secs = m_secs + 1; end
        else m_ms = m_ms + 1;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk)
    if (rst_n && !done) chk({m_req, " model"}, rdata, m_rdata);

  task automatic drv(input logic t, r, w, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    tick = t; rd_en = r; wr_en = w; addr = a; wdata = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drv(0, 0, 0, 8'h00, 0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) drv(1, 0, 0, 8'h00, 0);
    idle(1);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    drv(0, 0, 1, a, d);
    idle(1);
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
    drv(0, 1, 0, a, 0);
    @(negedge clk);
    tick = 0; rd_en = 0; wr_en = 0;
    chk(req, rdata, exp);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    chk("R1 rdata", rdata, 0);
    rd_chk(8'h08, 0, "R1 secs");
    rd_chk(8'h0C, 0, "R1 capt");
    rd_chk(8'h10, 0, "R1 ms");

    ticks(7);
    rd_chk(8'h10, 7, "R2 ms after 7 ticks");
    idle(20);
    rd_chk(8'h10, 7, "R2 ms held without tick");

    drv(1, 0, 1, 8'h08, 32'h1234); idle(1);
    rd_chk(8'h08, 32'h1234, "R7 secs load");
    rd_chk(8'h10, 0, "R7 ms cleared over tick");

    ticks(999);
    rd_chk(8'h10, 999, "R2 ms at 999");
    ticks(1);
    rd_chk(8'h10, 0, "R3 ms rolled");
    rd_chk(8'h08, 32'h1235, "R3 secs incremented");

    rd_chk(8'h10, 0, "R4 ms read");
    wr(8'h08, 32'h50);
    rd_chk(8'h0C, 32'h1235, "R5 capt held across write");
    rd_chk(8'h08, 32'h50, "R6 live secs");

    wr(8'h08, 7);
    ticks(999);
    drv(1, 1, 0, 8'h10, 0);
    @(negedge clk); tick = 0; rd_en = 0;
    chk("R10 ms on rollover", rdata, 999);
    rd_chk(8'h0C, 7, "R10 capt pre-increment");
    rd_chk(8'h08, 8, "R10 secs after rollover");

    wr(8'h08, 32'hFFFF_FFFF);
    ticks(1000);
    rd_chk(8'h08, 0, "R11 secs wrapped");
    rd_chk(8'h10, 0, "R11 ms zero");

    ticks(3);
    rd_chk(8'h10, 3, "R8 ms before stray writes");
    wr(8'h10, 32'h55);
    wr(8'h0C, 32'h66);
    wr(8'h20, 32'h77);
    rd_chk(8'h0C, 0, "R8 capt unchanged");
    rd_chk(8'h10, 3, "R8 ms unchanged");
    rd_chk(8'h08, 0, "R8 secs unchanged");

    rd_chk(8'h04, 0, "R9 unmapped 04");
    rd_chk(8'h20, 0, "R9 unmapped 20");
    rd_chk(8'hFF, 0, "R9 unmapped FF");
    idle(1);
    chk("R9 idle rdata", rdata, 0);

    wr(8'h08, 32'h100);
    rd_chk(8'h10, 0, "R12 first ms read");
    wr(8'h08, 32'h200);
    rd_chk(8'h10, 0, "R12 second ms read");
    rd_chk(8'h0C, 32'h200, "R12 capt overwritten");

    idle(4);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule